// File: doc/BRIEF.md
# Two-Operand Register ALU Execute Unit

This block is the execute stage for the register-to-register arithmetic and logic group of a compact 16-bit instruction format. Each issued operation carries a 4-bit operation code, the 3-bit index of the destination register, the current value of that destination register and the value of the source register, along with the current carry and overflow flags. One clock later the unit presents the 32-bit result, the destination index, a write-enable for the register file and the new N, Z, C and V flags.

The register file read happens upstream. The unit therefore takes operand values, not the source register index. The flag register lives outside the unit. The unit always returns all four flag values, and where an operation leaves a flag untouched it passes back the incoming value. Compare and test operations compute their result and flags as usual but hold the write-enable low.

Top module: `alu_exec`

## Requirements
- R1: Operation codes decode as 0 AND, 1 EOR, 2 LSL, 3 LSR, 4 ASR, 5 ADC, 6 SBC, 7 ROR, 8 TST, 9 NEG, 10 CMP, 11 CMN, 12 ORR, 13 MUL, 14 BIC (destination AND inverted source), 15 MVN (inverted source). For every code, N equals result bit 31 and Z is set exactly when the result is zero.
- R2: Codes 8, 10 and 11 produce flags and a result value but hold `wrEn` low. All other codes raise `wrEn`.
- R3: NEG returns zero minus the source, computed as a subtract with carry-in 1. C is the not-borrow and V is the signed overflow.
- R4: ADC returns destination + source + carry flag. SBC returns destination − source − (1 − carry flag). Both set C from the adder carry-out (not-borrow for subtract) and V from signed overflow.
- R5: CMP flags follow destination − source with carry-in 1. CMN flags follow destination + source with carry-in 0.
- R6: AND, EOR, ORR, BIC, MVN and TST return C and V equal to the incoming carry and overflow flags.
- R7: A shift or rotate whose amount (bits 7:0 of the source) is zero returns the destination unchanged and passes through the incoming carry. Bits 31:8 of the source never affect any shift.
- R8: For amounts 1 to 31, LSL, LSR and ASR return the shifted value with C equal to the last bit shifted out. At amount 32, LSL gives 0 with C equal to destination bit 0, LSR gives 0 with C equal to bit 31, and ASR gives 32 copies of bit 31 with C equal to bit 31. All shifts leave V unchanged.
- R9: For amounts above 32, LSL and LSR return 0 with C cleared, and ASR returns 32 copies of bit 31 with C equal to bit 31.
- R10: ROR by a nonzero amount rotates right by that amount modulo 32. C equals bit 31 of the result and V is unchanged.
- R11: MUL returns the low 32 bits of destination × source and passes through the incoming C and V.
- R12: An operation issued with `issueValid` high at a rising edge appears on the outputs after that edge, with `resValid` high and `wrIdx` equal to the issued destination index. An edge without issue drives `resValid` and `wrEn` low.
- R13: While `rstN` is low, every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| issueValid | input | 1 | An operation is presented this cycle |
| opCode | input | 4 | Operation code |
| dstIdx | input | 3 | Destination register index |
| dstVal | input | 32 | Current destination register value (first operand) |
| srcVal | input | 32 | Source register value (second operand, shift amount) |
| carryIn | input | 1 | Current C flag |
| ovfIn | input | 1 | Current V flag |
| resValid | output | 1 | Result registered this cycle |
| wrEn | output | 1 | Write result to the register file |
| wrIdx | output | 3 | Register to write |
| resData | output | 32 | Result value |
| flagN | output | 1 | New N flag |
| flagZ | output | 1 | New Z flag |
| flagC | output | 1 | New C flag |
| flagV | output | 1 | New V flag |

## Verification
The assertions take for granted that the carry and overflow inputs, the operands and the operation code are stable, known values in any cycle where `issueValid` is high. They relate each registered output only to the values issued one edge earlier, so they assume nothing about how operations are spaced. The stimulus drives every input on the falling edge, so values are settled at each rising edge. It keeps every field at a defined value, including during idle cycles, and mixes back-to-back issues with idle gaps.

// File: rtl/alu_exec_pkg.sv
package alu_exec_pkg;

  typedef enum logic [3:0] {
    OP_AND = 4'd0,  OP_EOR = 4'd1,  OP_LSL = 4'd2,  OP_LSR = 4'd3,
    OP_ASR = 4'd4,  OP_ADC = 4'd5,  OP_SBC = 4'd6,  OP_ROR = 4'd7,
    OP_TST = 4'd8,  OP_NEG = 4'd9,  OP_CMP = 4'd10, OP_CMN = 4'd11,
    OP_ORR = 4'd12, OP_MUL = 4'd13, OP_BIC = 4'd14, OP_MVN = 4'd15
  } aluOp_e;

  typedef enum logic [1:0] {RES_LOGIC, RES_SHIFT, RES_ADD, RES_MUL} resSel_e;
  typedef enum logic [1:0] {LG_AND, LG_EOR, LG_ORR, LG_PASS} logicSel_e;
  typedef enum logic [1:0] {SH_LSL, SH_LSR, SH_ASR, SH_ROR} shiftSel_e;
  typedef enum logic [1:0] {CIN_ZERO, CIN_ONE, CIN_FLAG} cinSel_e;

  // Strobes from control to datapath
  typedef struct packed {
    resSel_e   resSel;
    logicSel_e logicSel;
    shiftSel_e shiftSel;
    cinSel_e   cinSel;
    logic      invSrc;    // invert source before logic unit / adder
    logic      zeroDst;   // replace destination operand by zero in adder
    logic      writeBack;
  } aluCtrl_t;

endpackage

// File: rtl/alu_exec_ctrl.sv
module alu_exec_ctrl
  import alu_exec_pkg::*;
(
  input  logic [3:0] opCode,
  output aluCtrl_t   ctrl
);

  always_comb begin
    ctrl           = '0;
    ctrl.resSel    = RES_LOGIC;
    ctrl.logicSel  = LG_AND;
    ctrl.shiftSel  = SH_LSL;
    ctrl.cinSel    = CIN_ZERO;
    ctrl.writeBack = 1'b1;
    unique case (aluOp_e'(opCode))
      OP_AND: ctrl.logicSel = LG_AND;
      OP_EOR: ctrl.logicSel = LG_EOR;
      OP_ORR: ctrl.logicSel = LG_ORR;
      OP_TST: begin ctrl.logicSel = LG_AND; ctrl.writeBack = 1'b0; end
      OP_BIC: begin ctrl.logicSel = LG_AND; ctrl.invSrc = 1'b1; end
      OP_MVN: begin ctrl.logicSel = LG_PASS; ctrl.invSrc = 1'b1; end
      OP_LSL: begin ctrl.resSel = RES_SHIFT; ctrl.shiftSel = SH_LSL; end
      OP_LSR: begin ctrl.resSel = RES_SHIFT; ctrl.shiftSel = SH_LSR; end
      OP_ASR: begin ctrl.resSel = RES_SHIFT; ctrl.shiftSel = SH_ASR; end
      OP_ROR: begin ctrl.resSel = RES_SHIFT; ctrl.shiftSel = SH_ROR; end
      OP_ADC: begin ctrl.resSel = RES_ADD; ctrl.cinSel = CIN_FLAG; end
      OP_SBC: begin
        ctrl.resSel = RES_ADD; ctrl.cinSel = CIN_FLAG; ctrl.invSrc = 1'b1;
      end
      OP_NEG: begin
        ctrl.resSel = RES_ADD; ctrl.cinSel = CIN_ONE; ctrl.invSrc = 1'b1;
        ctrl.zeroDst = 1'b1;
      end
      OP_CMP: begin
        ctrl.resSel = RES_ADD; ctrl.cinSel = CIN_ONE; ctrl.invSrc = 1'b1;
        ctrl.writeBack = 1'b0;
      end
      OP_CMN: begin
        ctrl.resSel = RES_ADD; ctrl.cinSel = CIN_ZERO; ctrl.writeBack = 1'b0;
      end
      OP_MUL: ctrl.resSel = RES_MUL;
      default: ;
    endcase
  end

endmodule

// File: rtl/alu_exec_dp.sv
module alu_exec_dp
  import alu_exec_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int SHAMT_W = 8
) (
  input  aluCtrl_t          ctrl,
  input  logic [DATA_W-1:0] dstVal,
  input  logic [DATA_W-1:0] srcVal,
  input  logic              carryIn,
  input  logic              ovfIn,
  output logic [DATA_W-1:0] result,
  output logic              nOut,
  output logic              zOut,
  output logic              cOut,
  output logic              vOut
);

  localparam int ROT_W = $clog2(DATA_W);

  // Shared operand preparation
  logic [DATA_W-1:0] srcMod;
  assign srcMod = ctrl.invSrc ? ~srcVal : srcVal;

  // Logic unit
  logic [DATA_W-1:0] logicRes;
  always_comb begin
    unique case (ctrl.logicSel)
      LG_AND:  logicRes = dstVal & srcMod;
      LG_EOR:  logicRes = dstVal ^ srcMod;
      LG_ORR:  logicRes = dstVal | srcMod;
      default: logicRes = srcMod;
    endcase
  end

  // Adder: carry-out is the not-borrow when the source is inverted
  logic [DATA_W-1:0] addX;
  logic              cinBit;
  logic [DATA_W:0]   sumExt;
  logic              addOvf;
  assign addX = ctrl.zeroDst ? '0 : dstVal;
  always_comb begin
    unique case (ctrl.cinSel)
      CIN_ONE:  cinBit = 1'b1;
      CIN_FLAG: cinBit = carryIn;
      default:  cinBit = 1'b0;
    endcase
  end
  assign sumExt = {1'b0, addX} + {1'b0, srcMod} + {{DATA_W{1'b0}}, cinBit};
  assign addOvf = (addX[DATA_W-1] == srcMod[DATA_W-1]) &&
                  (sumExt[DATA_W-1] != addX[DATA_W-1]);

  // Shifter, amount from the low byte of the source register
  logic [SHAMT_W-1:0] amt;
  logic [ROT_W-1:0]   rot;
  logic [DATA_W:0]    lslExt;
  logic [DATA_W:0]    lsrExt;
  logic [DATA_W:0]    asrExt;
  logic [DATA_W-1:0]  rorRes;
  logic [DATA_W-1:0]  shiftRes;
  logic               shiftC;
  assign amt    = srcVal[SHAMT_W-1:0];
  assign rot    = amt[ROT_W-1:0];
  assign lslExt = {1'b0, dstVal} << amt;
  assign lsrExt = {dstVal, 1'b0} >> amt;
  assign asrExt = $unsigned($signed({dstVal, 1'b0}) >>> amt);
  assign rorRes = (dstVal >> rot) | (dstVal << (DATA_W - int'(rot)));

  always_comb begin
    if (amt == '0) begin
      shiftRes = dstVal;
      shiftC   = carryIn;
    end else begin
      unique case (ctrl.shiftSel)
        SH_LSL:  begin shiftRes = lslExt[DATA_W-1:0]; shiftC = lslExt[DATA_W]; end
        SH_LSR:  begin shiftRes = lsrExt[DATA_W:1];   shiftC = lsrExt[0]; end
        SH_ASR:  begin shiftRes = asrExt[DATA_W:1];   shiftC = asrExt[0]; end
        default: begin shiftRes = rorRes;             shiftC = rorRes[DATA_W-1]; end
      endcase
    end
  end

  // Multiplier, low half only
  logic [DATA_W-1:0] mulRes;
  assign mulRes = dstVal * srcVal;

  // Result and flag select
  always_comb begin
    cOut = carryIn;
    vOut = ovfIn;
    unique case (ctrl.resSel)
      RES_SHIFT: begin result = shiftRes; cOut = shiftC; end
      RES_ADD:   begin result = sumExt[DATA_W-1:0]; cOut = sumExt[DATA_W]; vOut = addOvf; end
      RES_MUL:   result = mulRes;
      default:   result = logicRes;
    endcase
  end
  assign nOut = result[DATA_W-1];
  assign zOut = (result == '0);

endmodule

// File: rtl/alu_exec.sv
module alu_exec
  import alu_exec_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IDX_W  = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              issueValid,
  input  logic [3:0]        opCode,
  input  logic [IDX_W-1:0]  dstIdx,
  input  logic [DATA_W-1:0] dstVal,
  input  logic [DATA_W-1:0] srcVal,
  input  logic              carryIn,
  input  logic              ovfIn,
  output logic              resValid,
  output logic              wrEn,
  output logic [IDX_W-1:0]  wrIdx,
  output logic [DATA_W-1:0] resData,
  output logic              flagN,
  output logic              flagZ,
  output logic              flagC,
  output logic              flagV
);

  aluCtrl_t          ctrl;
  logic [DATA_W-1:0] result;
  logic              nNext, zNext, cNext, vNext;

  alu_exec_ctrl u_ctrl (
    .opCode (opCode),
    .ctrl   (ctrl)
  );

  alu_exec_dp #(.DATA_W(DATA_W)) u_dp (
    .ctrl    (ctrl),
    .dstVal  (dstVal),
    .srcVal  (srcVal),
    .carryIn (carryIn),
    .ovfIn   (ovfIn),
    .result  (result),
    .nOut    (nNext),
    .zOut    (zNext),
    .cOut    (cNext),
    .vOut    (vNext)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      resValid <= 1'b0;
      wrEn     <= 1'b0;
      wrIdx    <= '0;
      resData  <= '0;
      flagN    <= 1'b0;
      flagZ    <= 1'b0;
      flagC    <= 1'b0;
      flagV    <= 1'b0;
    end else begin
      resValid <= issueValid;
      wrEn     <= issueValid && ctrl.writeBack;
      if (issueValid) begin
        wrIdx   <= dstIdx;
        resData <= result;
        flagN   <= nNext;
        flagZ   <= zNext;
        flagC   <= cNext;
        flagV   <= vNext;
      end
    end
  end

endmodule

// File: rtl/alu_exec_chk.sv
module alu_exec_chk #(
  parameter int DATA_W = 32,
  parameter int IDX_W  = 3
) (
  input logic              clk,
  input logic              rstN,
  input logic              issueValid,
  input logic [3:0]        opCode,
  input logic [IDX_W-1:0]  dstIdx,
  input logic [DATA_W-1:0] dstVal,
  input logic [DATA_W-1:0] srcVal,
  input logic              carryIn,
  input logic              ovfIn,
  input logic              resValid,
  input logic              wrEn,
  input logic [IDX_W-1:0]  wrIdx,
  input logic [DATA_W-1:0] resData,
  input logic              flagN,
  input logic              flagZ,
  input logic              flagC,
  input logic              flagV
);

  a_r1_nz_track: assert property (@(posedge clk) disable iff (!rstN)
    resValid |-> (flagN == resData[DATA_W-1]) && (flagZ == (resData == '0)));

  a_r2_compare_no_write: assert property (@(posedge clk) disable iff (!rstN)
    issueValid && (opCode == 4'd8 || opCode == 4'd10 || opCode == 4'd11)
      |=> resValid && !wrEn);

  a_r3_negate: assert property (@(posedge clk) disable iff (!rstN)
    issueValid && opCode == 4'd9 |=> (resData + $past(srcVal)) == '0);

  a_r6_logic_keeps_cv: assert property (@(posedge clk) disable iff (!rstN)
    issueValid && (opCode == 4'd0 || opCode == 4'd1 || opCode == 4'd8 ||
                   opCode == 4'd12 || opCode == 4'd14 || opCode == 4'd15)
      |=> flagC == $past(carryIn) && flagV == $past(ovfIn));

  a_r7_zero_amount: assert property (@(posedge clk) disable iff (!rstN)
    issueValid && (opCode == 4'd2 || opCode == 4'd3 || opCode == 4'd4 ||
                   opCode == 4'd7) && srcVal[7:0] == 8'd0
      |=> resData == $past(dstVal) && flagC == $past(carryIn));

  a_r8_lsl_by_width: assert property (@(posedge clk) disable iff (!rstN)
    issueValid && opCode == 4'd2 && srcVal[7:0] == 8'd32
      |=> resData == '0 && flagC == $past(dstVal[0]));

  a_r12_issue_tracks: assert property (@(posedge clk) disable iff (!rstN)
    issueValid |=> resValid && wrIdx == $past(dstIdx));

  a_r12_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !issueValid |=> !resValid && !wrEn);

  a_r13_reset_quiet: assert property (@(posedge clk)
    !rstN |-> !resValid && !wrEn);

endmodule

bind alu_exec alu_exec_chk #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_chk (.*);

// File: tb/alu_exec_bench.sv
module alu_exec_bench;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        issueValid = 1'b0;
  logic [3:0]  opCode = '0;
  logic [2:0]  dstIdx = '0;
  logic [31:0] dstVal = '0;
  logic [31:0] srcVal = '0;
  logic        carryIn = 1'b0;
  logic        ovfIn = 1'b0;
  logic        resValid, wrEn;
  logic [2:0]  wrIdx;
  logic [31:0] resData;
  logic        flagN, flagZ, flagC, flagV;

  int total = 0;
  int bad   = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  alu_exec u_alu_exec (
    .clk(clk), .rstN(rstN), .issueValid(issueValid), .opCode(opCode),
    .dstIdx(dstIdx), .dstVal(dstVal), .srcVal(srcVal), .carryIn(carryIn),
    .ovfIn(ovfIn), .resValid(resValid), .wrEn(wrEn), .wrIdx(wrIdx),
    .resData(resData), .flagN(flagN), .flagZ(flagZ), .flagC(flagC),
    .flagV(flagV)
  );

  typedef struct {
    logic [31:0] res;
    logic        wr;
    logic [2:0]  idx;
    logic [3:0]  nzcv;
    string       tag;
  } expItem_t;

  expItem_t expQ[$];

  // Independent model: arithmetic via wide signed sums, shifts one bit at a time
  function automatic void addRef(input logic [31:0] a, input logic [31:0] b,
                                 input logic ci, output logic [31:0] r,
                                 output logic c, output logic v);
    logic [32:0] s;
    longint      sw;
    s  = {1'b0, a} + {1'b0, b} + {32'd0, ci};
    r  = s[31:0];
    c  = s[32];
    sw = longint'($signed(a)) + longint'($signed(b)) + longint'(ci);
    v  = (sw != longint'($signed(r)));
  endfunction

  function automatic void subRef(input logic [31:0] a, input logic [31:0] b,
                                 input logic ci, output logic [31:0] r,
                                 output logic c, output logic v);
    logic   brw;
    longint sw;
    brw = ~ci;
    r   = a - b - {31'd0, brw};
    c   = ({1'b0, a} >= ({1'b0, b} + {32'd0, brw}));
    sw  = longint'($signed(a)) - longint'($signed(b)) - longint'(brw);
    v   = (sw != longint'($signed(r)));
  endfunction

  function automatic expItem_t model(input logic [3:0] op, input logic [31:0] a,
                                     input logic [31:0] b, input logic ci,
                                     input logic vi, input logic [2:0] idx);
    expItem_t    e;
    logic [31:0] r;
    logic        c, v, w;
    int          amt;
    string       t;
    c = ci; v = vi; w = 1'b1; r = a; amt = int'(b[7:0]);
    case (op)
      4'd0:  begin r = a & b;  t = "R6"; end
      4'd1:  begin r = a ^ b;  t = "R6"; end
      4'd12: begin r = a | b;  t = "R6"; end
      4'd14: begin r = a & ~b; t = "R6"; end
      4'd15: begin r = ~b;     t = "R6"; end
      4'd8:  begin r = a & b; w = 1'b0; t = "R2,R6"; end
      4'd2: begin
        for (int i = 0; i < amt; i++) begin c = r[31]; r = r << 1; end
        t = "R8";
      end
      4'd3: begin
        for (int i = 0; i < amt; i++) begin c = r[0]; r = r >> 1; end
        t = "R8";
      end
      4'd4: begin
        for (int i = 0; i < amt; i++) begin c = r[0]; r = {r[31], r[31:1]}; end
        t = "R8";
      end
      4'd7: begin
        for (int i = 0; i < amt; i++) r = {r[0], r[31:1]};
        if (amt != 0) c = r[31];
        t = "R10";
      end
      4'd5:  begin addRef(a, b, ci, r, c, v); t = "R4"; end
      4'd6:  begin subRef(a, b, ci, r, c, v); t = "R4"; end
      4'd9:  begin subRef(32'd0, b, 1'b1, r, c, v); t = "R3"; end
      4'd10: begin subRef(a, b, 1'b1, r, c, v); w = 1'b0; t = "R2,R5"; end
      4'd11: begin addRef(a, b, 1'b0, r, c, v); w = 1'b0; t = "R2,R5"; end
      default: begin r = a * b; t = "R11"; end
    endcase
    if ((op == 4'd2 || op == 4'd3 || op == 4'd4 || op == 4'd7) && amt == 0)
      t = "R7";
    else if ((op == 4'd2 || op == 4'd3 || op == 4'd4) && amt > 32)
      t = "R9";
    e.res  = r;
    e.wr   = w;
    e.idx  = idx;
    e.nzcv = {r[31], r == 32'd0, c, v};
    e.tag  = {"R1,R12,", t};
    return e;
  endfunction

  task automatic issue(input logic [3:0] op, input logic [31:0] a,
                       input logic [31:0] b, input logic ci, input logic vi,
                       input logic [2:0] idx);
    @(negedge clk);
    issueValid = 1'b1;
    opCode = op; dstVal = a; srcVal = b; carryIn = ci; ovfIn = vi; dstIdx = idx;
    expQ.push_back(model(op, a, b, ci, vi, idx));
  endtask

  task automatic idle();
    @(negedge clk);
    issueValid = 1'b0;
    opCode = 4'd0; dstVal = '0; srcVal = '0; carryIn = 1'b0; ovfIn = 1'b0;
    dstIdx = '0;
  endtask

  // Monitor: each registered result is compared against the oldest expectation
  always @(negedge clk) begin
    if (rstN && !finished && resValid) begin
      total++;
      if (expQ.size() == 0) begin
        bad++;
        $display("FAIL R12: result with nothing issued, actual resData=%h expected none",
                 resData);
      end else begin
        expItem_t e;
        e = expQ.pop_front();
        if (resData !== e.res || wrEn !== e.wr || wrIdx !== e.idx ||
            {flagN, flagZ, flagC, flagV} !== e.nzcv) begin
          bad++;
          $display("FAIL %s: actual res=%h wr=%b idx=%0d nzcv=%b expected res=%h wr=%b idx=%0d nzcv=%b",
                   e.tag, resData, wrEn, wrIdx, {flagN, flagZ, flagC, flagV},
                   e.res, e.wr, e.idx, e.nzcv);
        end
      end
    end else if (rstN && !finished && wrEn) begin
      total++; bad++;
      $display("FAIL R12: actual wrEn=1 expected 0 while idle");
    end
  end

  initial begin
    repeat (60000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  localparam logic [31:0] A_SET [6] = '{32'h0, 32'h1, 32'h7fffffff,
                                        32'h80000000, 32'hffffffff, 32'h12345678};
  localparam logic [31:0] B_SET [12] = '{32'd0, 32'd1, 32'd31, 32'd32, 32'd33,
                                         32'd255, 32'd256, 32'h101, 32'h80000000,
                                         32'hffffffff, 32'h7fffffff, 32'd4};

  initial begin
    // R13: outputs quiet during and after reset
    repeat (3) @(negedge clk);
    total++;
    if (resValid !== 1'b0 || wrEn !== 1'b0 || resData !== 32'd0 ||
        {flagN, flagZ, flagC, flagV} !== 4'b0000 || wrIdx !== 3'd0) begin
      bad++;
      $display("FAIL R13: actual valid=%b wr=%b res=%h nzcv=%b expected all zero",
               resValid, wrEn, resData, {flagN, flagZ, flagC, flagV});
    end
    rstN = 1'b1;

    // Corner sweep over every code
    for (int op = 0; op < 16; op++)
      for (int ia = 0; ia < 6; ia++)
        for (int ib = 0; ib < 12; ib++)
          for (int ci = 0; ci < 2; ci++)
            issue(4'(op), A_SET[ia], B_SET[ib], 1'(ci), 1'(ib & 1), 3'(ia + ib));
    idle();

    // Random operands, random gaps
    for (int n = 0; n < 1500; n++) begin
      logic [31:0] a, b;
      a = $urandom();
      b = $urandom();
      if (n % 3 == 0) b = {b[31:8], 8'($urandom_range(0, 40))};
      issue(4'($urandom_range(0, 15)), a, b, 1'($urandom_range(0, 1)),
            1'($urandom_range(0, 1)), 3'($urandom_range(0, 7)));
      if (n % 7 == 0) idle();
    end
    idle();
    idle();
    idle();

    // R12: every issued operation produced a result
    total++;
    if (expQ.size() != 0) begin
      bad++;
      $display("FAIL R12: actual %0d results missing expected 0", expQ.size());
    end
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule